// File: doc/BRIEF.md
# Opportunistic Video Memory Write-Slot Arbiter

This block decides, slot by slot, who owns a 16-bit video memory that a tile renderer keeps busy for most of each scanline. CPU writes (word address plus data) enter a small queue at any time. On every memory slot the arbiter either passes the renderer's read through untouched or, when the renderer's fetch is provably unnecessary, hands the slot to the oldest queued write. The CPU is therefore never held off until blanking, and rendering is never stalled.

A slot is declared free during vertical blanking, and on visible lines when its background layer is switched off in all four enable masks, when the pattern fetch would load the layer's designated transparent tile, when the pattern fetch would reload exactly the sliver already cached for that layer, when it belongs to the spare last tile column, or when it is a sprite slot in horizontal blanking beyond the number of sprite slivers found. A free slot is reported to the renderer through `free_o` and `reason_o` so it can substitute transparent or cached pixels. When a slot is free but the queue is empty, the renderer's read still goes out.

Top module: `vram_slot_arbiter`

## Requirements
- R1: Queued writes reach memory exactly once and in push order; `q_full_o` is high at 16 entries; a push while full is discarded and `q_ovf_o` pulses high for the one cycle after it.
- R2: With `vblank_i` high every valid slot is free with reason 1, and it carries a queued write if one is waiting.
- R3: A background layer whose bit is clear in all four masks (main, sub, main-window, sub-window) has every nametable (kind 0) and pattern (kind 1) slot free with reason 2; a bit set in any one mask keeps it rendered.
- R4: A pattern slot is free with reason 3 when the nametable entry read in that layer's last nametable slot has bits [9:0] equal to the layer's transparent tile number; nametable slots are never freed by this rule or by R5.
- R5: A pattern slot is free with reason 4 when tile bits [9:0], vertical-flip bit 15 and the fine row `fine_y_i` all match the last sliver actually fetched for that layer; that cache is cleared by horizontal or vertical blanking and by any queued write reaching memory.
- R6: Nametable and pattern slots in column 33 (the 34th) are free with reason 5.
- R7: During `hblank_i`, a sprite slot (kind 2) whose index `slot_col_i` is at or above `spr_count_i` is free with reason 6; the others are kept.
- R8: When several rules apply, the reported reason follows the order vblank, layer off, transparent, repeat, spare column, sprite shortfall; reason 0 means not free.
- R9: A slot that is not free issues a read (`mem_en_o`=1, `mem_we_o`=0) at `rnd_addr_i`.
- R10: A free slot with an empty queue still issues the renderer's read and no write.
- R11: After reset the queue is empty, not full, and the overflow flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_wr_i | input | 1 | Push one write into the queue |
| cpu_addr_i | input | 15 | Word address of the pushed write |
| cpu_data_i | input | 16 | Data of the pushed write |
| q_full_o | output | 1 | Queue holds 16 entries |
| q_empty_o | output | 1 | Queue holds no entries |
| q_ovf_o | output | 1 | Pulse after a push was refused |
| slot_valid_i | input | 1 | A memory slot occurs this cycle |
| slot_kind_i | input | 2 | 0 nametable, 1 pattern, 2 sprite, 3 none |
| slot_layer_i | input | 2 | Background layer of the slot |
| slot_col_i | input | 6 | Tile column, or sprite slot index |
| fine_y_i | input | 3 | Fine row used by a pattern fetch |
| rnd_addr_i | input | 15 | Renderer fetch address |
| vblank_i | input | 1 | Vertical blanking |
| hblank_i | input | 1 | Horizontal blanking |
| spr_count_i | input | 6 | Sprite slivers found for the next line |
| en_main_i | input | 4 | Main-screen layer enables |
| en_sub_i | input | 4 | Sub-screen layer enables |
| en_win_main_i | input | 4 | Main-window layer enables |
| en_win_sub_i | input | 4 | Sub-window layer enables |
| transp_tiles_i | input | 40 | Transparent tile number per layer, layer n at [10n+9:10n] |
| mem_rdata_i | input | 16 | Read data returned in the same slot |
| mem_en_o | output | 1 | Memory access this slot |
| mem_we_o | output | 1 | Access is a queued write |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| free_o | output | 1 | Slot's render fetch is unnecessary |
| reason_o | output | 3 | Why the slot is free (see R8) |

## Verification
The collision that matters is a CPU push landing in the same cycle as a drain while the queue is full: the pop frees a place only after the edge, so the push must be refused, the overflow pulse must follow, and the remaining sixteen entries must still drain in order with the refused word never appearing in memory. The bench provokes it with a vblank slot and a push together and judges it by the write log captured at the memory port. A second collision is a queued write taking a repeat-freed slot: the write has to clear the sliver cache so the very next identical pattern fetch is performed, which the bench observes as a required read in the following pattern slot.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    SLOT_NAME = 2'd0,
    SLOT_PAT  = 2'd1,
    SLOT_SPR  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_kind_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_VBLANK   = 3'd1,
    RSN_LAYER_OFF= 3'd2,
    RSN_TRANSP   = 3'd3,
    RSN_REPEAT   = 3'd4,
    RSN_SPARE    = 3'd5,
    RSN_SPR_SHORT= 3'd6
  } reason_e;
endpackage

// File: rtl/vsa_wr_fifo.sv
module vsa_wr_fifo #(
  parameter int DEPTH = 16,
  parameter int AW    = 15,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      ovf_o <= push_i && full_o;
      if (do_push) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_ovf_on_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> ovf_o);
  assert_no_pop_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_flags_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_full_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/vsa_reclaim.sv
module vsa_reclaim
  import vsa_pkg::*;
#(
  parameter int NLAYER = 4,
  parameter int TILE_W = 10,
  parameter int NCOL   = 34,
  parameter int DW     = 16,
  parameter int VFLIP_BIT = 15,
  localparam int LW = $clog2(NLAYER),
  localparam int CW = $clog2(NCOL + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_valid_i,
  input  logic [1:0]               slot_kind_i,
  input  logic [LW-1:0]            slot_layer_i,
  input  logic [CW-1:0]            slot_col_i,
  input  logic [2:0]               fine_y_i,
  input  logic                     vblank_i,
  input  logic                     hblank_i,
  input  logic [CW-1:0]            spr_count_i,
  input  logic [NLAYER-1:0]        en_main_i,
  input  logic [NLAYER-1:0]        en_sub_i,
  input  logic [NLAYER-1:0]        en_win_main_i,
  input  logic [NLAYER-1:0]        en_win_sub_i,
  input  logic [NLAYER*TILE_W-1:0] transp_tiles_i,
  input  logic [DW-1:0]            rd_data_i,
  input  logic                     rd_done_i,
  input  logic                     wr_done_i,
  output logic                     free_o,
  output logic [2:0]               reason_o
);
  typedef struct packed {
    logic              vld;
    logic [TILE_W-1:0] tile;
    logic              vflip;
    logic [2:0]        fy;
  } sliver_t;

  logic [TILE_W-1:0] transp_tile [NLAYER];
  logic [DW-1:0]     nt_q  [NLAYER];
  logic [NLAYER-1:0] nt_vld_q;
  sliver_t           cache_q [NLAYER];

  for (genvar l = 0; l < NLAYER; l++) begin : g_unpack
    assign transp_tile[l] = transp_tiles_i[l*TILE_W +: TILE_W];
  end

  logic              is_name, is_pat, is_bg, layer_on;
  logic [TILE_W-1:0] cur_tile;
  logic              cur_vflip, transp_hit, rep_hit, spare_hit, spr_hit;
  reason_e           reason;
  sliver_t           cur_c;

  assign is_name   = slot_kind_i == SLOT_NAME;
  assign is_pat    = slot_kind_i == SLOT_PAT;
  assign is_bg     = is_name || is_pat;
  assign layer_on  = en_main_i[slot_layer_i] | en_sub_i[slot_layer_i] |
                     en_win_main_i[slot_layer_i] | en_win_sub_i[slot_layer_i];
  assign cur_tile  = nt_q[slot_layer_i][TILE_W-1:0];
  assign cur_vflip = nt_q[slot_layer_i][VFLIP_BIT];
  assign cur_c     = cache_q[slot_layer_i];
  assign transp_hit = is_pat && nt_vld_q[slot_layer_i] && (cur_tile == transp_tile[slot_layer_i]);
  assign rep_hit    = is_pat && nt_vld_q[slot_layer_i] && cur_c.vld &&
                      (cur_c.tile == cur_tile) && (cur_c.vflip == cur_vflip) && (cur_c.fy == fine_y_i);
  assign spare_hit  = is_bg && (slot_col_i == CW'(NCOL-1));
  assign spr_hit    = (slot_kind_i == SLOT_SPR) && hblank_i && (slot_col_i >= spr_count_i);

  // fixed priority: first matching rule names the reason
  always_comb begin
    reason = RSN_NONE;
    if (!slot_valid_i)          reason = RSN_NONE;
    else if (vblank_i)          reason = RSN_VBLANK;
    else if (is_bg && !layer_on) reason = RSN_LAYER_OFF;
    else if (transp_hit)        reason = RSN_TRANSP;
    else if (rep_hit)           reason = RSN_REPEAT;
    else if (spare_hit)         reason = RSN_SPARE;
    else if (spr_hit)           reason = RSN_SPR_SHORT;
  end

  assign reason_o = reason;
  assign free_o   = (reason != RSN_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nt_vld_q <= '0;
      for (int l = 0; l < NLAYER; l++) begin
        nt_q[l]    <= '0;
        cache_q[l] <= '0;
      end
    end else if (hblank_i || vblank_i) begin
      nt_vld_q <= '0;
      for (int l = 0; l < NLAYER; l++) cache_q[l].vld <= 1'b0;
    end else begin
      for (int l = 0; l < NLAYER; l++) begin
        if (slot_valid_i && is_name && slot_layer_i == LW'(l)) begin
          nt_vld_q[l] <= rd_done_i;
          if (rd_done_i) nt_q[l] <= rd_data_i;
        end
        // a write may have touched cached pattern data
        if (wr_done_i) cache_q[l].vld <= 1'b0;
        else if (slot_valid_i && is_pat && !free_o && slot_layer_i == LW'(l))
          cache_q[l] <= '{vld: 1'b1, tile: cur_tile, vflip: cur_vflip, fy: fine_y_i};
      end
    end
  end

  assert_vblank_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && vblank_i) |-> (free_o && reason_o == 3'd1));
  assert_name_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && is_name) |-> (reason_o != 3'd3 && reason_o != 3'd4));
  assert_cache_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_i |=> (reason_o != 3'd4));
  assert_spr_in_hblank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o == 3'd6) |-> (hblank_i && slot_kind_i == 2'd2));
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
  import vsa_pkg::*;
#(
  parameter int NLAYER = 4,
  parameter int TILE_W = 10,
  parameter int NCOL   = 34,
  parameter int QDEPTH = 16,
  parameter int AW     = 15,
  parameter int DW     = 16,
  localparam int LW = $clog2(NLAYER),
  localparam int CW = $clog2(NCOL + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cpu_wr_i,
  input  logic [AW-1:0]            cpu_addr_i,
  input  logic [DW-1:0]            cpu_data_i,
  output logic                     q_full_o,
  output logic                     q_empty_o,
  output logic                     q_ovf_o,
  input  logic                     slot_valid_i,
  input  logic [1:0]               slot_kind_i,
  input  logic [LW-1:0]            slot_layer_i,
  input  logic [CW-1:0]            slot_col_i,
  input  logic [2:0]               fine_y_i,
  input  logic [AW-1:0]            rnd_addr_i,
  input  logic                     vblank_i,
  input  logic                     hblank_i,
  input  logic [CW-1:0]            spr_count_i,
  input  logic [NLAYER-1:0]        en_main_i,
  input  logic [NLAYER-1:0]        en_sub_i,
  input  logic [NLAYER-1:0]        en_win_main_i,
  input  logic [NLAYER-1:0]        en_win_sub_i,
  input  logic [NLAYER*TILE_W-1:0] transp_tiles_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     mem_en_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  output logic                     free_o,
  output logic [2:0]               reason_o
);
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          grant, render_rd;

  vsa_wr_fifo #(.DEPTH(QDEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(cpu_wr_i), .push_addr_i(cpu_addr_i), .push_data_i(cpu_data_i),
    .pop_i(grant), .head_addr_o(head_addr), .head_data_o(head_data),
    .full_o(q_full_o), .empty_o(q_empty_o), .ovf_o(q_ovf_o)
  );

  vsa_reclaim #(.NLAYER(NLAYER), .TILE_W(TILE_W), .NCOL(NCOL), .DW(DW)) u_reclaim (
    .clk_i, .rst_ni,
    .slot_valid_i, .slot_kind_i, .slot_layer_i, .slot_col_i, .fine_y_i,
    .vblank_i, .hblank_i, .spr_count_i,
    .en_main_i, .en_sub_i, .en_win_main_i, .en_win_sub_i, .transp_tiles_i,
    .rd_data_i(mem_rdata_i), .rd_done_i(render_rd), .wr_done_i(grant),
    .free_o, .reason_o
  );

  assign grant       = slot_valid_i && free_o && !q_empty_o;
  assign render_rd   = slot_valid_i && !grant && (slot_kind_i != SLOT_NONE);
  assign mem_en_o    = grant || render_rd;
  assign mem_we_o    = grant;
  assign mem_addr_o  = grant ? head_addr : rnd_addr_i;
  assign mem_wdata_o = head_data;

  assert_fetch_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && !free_o && slot_kind_i != 2'd3) |->
      (mem_en_o && !mem_we_o && mem_addr_o == rnd_addr_i));
  assert_idle_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && q_empty_o) |-> !mem_we_o);
  assert_drain_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && free_o && !q_empty_o) |-> (mem_en_o && mem_we_o));
endmodule

// File: tb/vram_slot_arbiter_tb_top.sv
module vram_slot_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [14:0] cpu_addr_i = '0;
  logic [15:0] cpu_data_i = '0;
  logic        q_full_o, q_empty_o, q_ovf_o;
  logic        slot_valid_i = 1'b0;
  logic [1:0]  slot_kind_i = 2'd3;
  logic [1:0]  slot_layer_i = '0;
  logic [5:0]  slot_col_i = '0;
  logic [2:0]  fine_y_i = '0;
  logic [14:0] rnd_addr_i = '0;
  logic        vblank_i = 1'b0, hblank_i = 1'b0;
  logic [5:0]  spr_count_i = '0;
  logic [3:0]  en_main_i = 4'hF, en_sub_i = '0, en_win_main_i = '0, en_win_sub_i = '0;
  logic [39:0] transp_tiles_i = {10'h3FF, 10'h3FF, 10'h3FF, 10'h005};
  logic [15:0] mem_rdata_i;
  logic        mem_en_o, mem_we_o, free_o;
  logic [14:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [2:0]  reason_o;

  logic [15:0] vmem [2048];
  logic [14:0] log_addr [64];
  logic [15:0] log_data [64];
  int          wr_n = 0;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  assign mem_rdata_i = vmem[mem_addr_o[10:0]];

  always @(posedge clk_i) begin
    if (mem_en_o && mem_we_o) begin
      vmem[mem_addr_o[10:0]] <= mem_wdata_o;
      if (wr_n < 64) begin
        log_addr[wr_n] = mem_addr_o;
        log_data[wr_n] = mem_wdata_o;
      end
      wr_n = wr_n + 1;
    end
  end

  vram_slot_arbiter dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
    @(posedge clk_i); #1;
    cpu_wr_i = 1'b0;
  endtask

  // one slot: drive at negedge, judge combinational outputs, let the edge pass
  task automatic do_slot(input logic [1:0] k, input int ly, input int cl, input logic [2:0] fy,
                         input logic [14:0] ra, input logic vb, input logic hb,
                         input logic ef, input logic [2:0] er, input logic ew,
                         input logic pw, input logic [14:0] pa, input logic [15:0] pd,
                         input string req);
    @(negedge clk_i);
    slot_valid_i = 1'b1; slot_kind_i = k; slot_layer_i = 2'(ly); slot_col_i = 6'(cl);
    fine_y_i = fy; rnd_addr_i = ra; vblank_i = vb; hblank_i = hb;
    cpu_wr_i = pw; cpu_addr_i = pa; cpu_data_i = pd;
    #1;
    check(free_o == ef && reason_o == er, req, "free/reason",
          {28'd0, free_o, reason_o}, {28'd0, ef, er});
    if (ew)
      check(mem_en_o && mem_we_o, req, "queued write", {30'd0, mem_en_o, mem_we_o}, 32'd3);
    else if (k != 2'd3)
      check(mem_en_o && !mem_we_o && mem_addr_o == ra, req, "render read",
            {15'd0, mem_addr_o, mem_en_o, mem_we_o}, {15'd0, ra, 2'b10});
    @(posedge clk_i); #1;
    cpu_wr_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
    slot_valid_i = 1'b0; slot_kind_i = 2'd3; vblank_i = 1'b0; hblank_i = 1'b0;
  endtask

  task automatic clear_line();
    @(negedge clk_i);
    slot_valid_i = 1'b0; hblank_i = 1'b1;
    @(negedge clk_i);
    hblank_i = 1'b0;
  endtask

  task automatic t_reset();
    check(q_empty_o && !q_full_o && !q_ovf_o, "R11", "reset flags",
          {29'd0, q_empty_o, q_full_o, q_ovf_o}, 32'd4);
  endtask

  task automatic t_fill_collide();
    for (int i = 0; i < 16; i++) push(15'h400 + 15'(i), 16'hA000 + 16'(i));
    check(q_full_o && !q_empty_o, "R1", "full at 16", {30'd0, q_full_o, q_empty_o}, 32'd2);
    // drain and refused push collide in one cycle
    do_slot(2'd3, 0, 0, 3'd0, 15'h0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b1, 1'b1, 15'h7FF, 16'hDEAD, "R2");
    check(q_ovf_o == 1'b1, "R1", "overflow pulse", {31'd0, q_ovf_o}, 32'd1);
    for (int i = 0; i < 15; i++)
      do_slot(2'd0, 1, i, 3'd0, 15'h10, 1'b1, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 15'h0, 16'h0, "R2");
    check(q_ovf_o == 1'b0, "R1", "overflow one cycle", {31'd0, q_ovf_o}, 32'd0);
    idle();
    check(q_empty_o, "R1", "empty after drain", {31'd0, q_empty_o}, 32'd1);
    check(wr_n == 16, "R1", "write count", 32'(wr_n), 32'd16);
    for (int i = 0; i < 16; i++)
      check(log_addr[i] == 15'h400 + 15'(i) && log_data[i] == 16'hA000 + 16'(i), "R1",
            "write order", {1'b0, log_addr[i], log_data[i]}, {1'b0, 15'h400 + 15'(i), 16'hA000 + 16'(i)});
    check(vmem[11'h7FF] == 16'h0, "R1", "refused word absent", {16'd0, vmem[11'h7FF]}, 32'd0);
  endtask

  task automatic t_disabled_spare();
    int base;
    base = wr_n;
    en_main_i = 4'b1001; en_sub_i = '0; en_win_main_i = '0; en_win_sub_i = 4'b0010;
    for (int i = 0; i < 6; i++) push(15'h500 + 15'(i), 16'hB000 + 16'(i));
    clear_line();
    do_slot(2'd0, 0, 0, 3'd0, 15'h010, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R9");
    do_slot(2'd1, 0, 0, 3'd0, 15'h200, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R9");
    do_slot(2'd0, 2, 0, 3'd0, 15'h011, 0, 0, 1'b1, 3'd2, 1'b1, 0, 0, 0, "R3");
    do_slot(2'd1, 2, 0, 3'd0, 15'h201, 0, 0, 1'b1, 3'd2, 1'b1, 0, 0, 0, "R3");
    do_slot(2'd0, 1, 0, 3'd0, 15'h012, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R3");
    do_slot(2'd0, 0, 33, 3'd0, 15'h013, 0, 0, 1'b1, 3'd5, 1'b1, 0, 0, 0, "R6");
    do_slot(2'd1, 0, 33, 3'd0, 15'h202, 0, 0, 1'b1, 3'd5, 1'b1, 0, 0, 0, "R6");
    do_slot(2'd0, 0, 32, 3'd0, 15'h014, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R6");
    idle();
    check(wr_n - base == 4, "R3", "writes in freed slots", 32'(wr_n - base), 32'd4);
    for (int i = 0; i < 4; i++)
      check(log_addr[base+i] == 15'h500 + 15'(i), "R1", "order across line",
            {17'd0, log_addr[base+i]}, {17'd0, 15'h500 + 15'(i)});
  endtask

  task automatic t_transparent();
    en_main_i = 4'hF; en_win_sub_i = '0;
    clear_line();
    do_slot(2'd0, 0, 1, 3'd0, 15'h100, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R4");
    do_slot(2'd1, 0, 1, 3'd0, 15'h210, 0, 0, 1'b1, 3'd3, 1'b1, 0, 0, 0, "R4");
    do_slot(2'd0, 0, 2, 3'd0, 15'h100, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R4");
    do_slot(2'd3, 0, 0, 3'd0, 15'h0, 1, 0, 1'b1, 3'd1, 1'b1, 0, 0, 0, "R2");
    idle();
    check(q_empty_o, "R1", "queue drained", {31'd0, q_empty_o}, 32'd1);
    check(vmem[11'h505] == 16'hB005, "R1", "last entry landed", {16'd0, vmem[11'h505]}, 32'hB005);
  endtask

  task automatic t_priority();
    en_main_i = 4'b1110;
    clear_line();
    do_slot(2'd0, 0, 3, 3'd0, 15'h100, 0, 0, 1'b1, 3'd2, 1'b0, 0, 0, 0, "R10");
    do_slot(2'd1, 0, 3, 3'd0, 15'h220, 0, 0, 1'b1, 3'd2, 1'b0, 0, 0, 0, "R8");
    en_main_i = 4'hF;
    do_slot(2'd0, 0, 33, 3'd0, 15'h100, 0, 0, 1'b1, 3'd5, 1'b0, 0, 0, 0, "R8");
    do_slot(2'd1, 0, 33, 3'd0, 15'h221, 0, 0, 1'b1, 3'd3, 1'b0, 0, 0, 0, "R8");
    idle();
  endtask

  task automatic t_repeat();
    clear_line();
    do_slot(2'd0, 0, 4, 3'd0, 15'h101, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd1, 0, 4, 3'd3, 15'h230, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd0, 0, 5, 3'd0, 15'h102, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd1, 0, 5, 3'd3, 15'h231, 0, 0, 1'b1, 3'd4, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd0, 0, 6, 3'd0, 15'h103, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd1, 0, 6, 3'd3, 15'h232, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd0, 0, 7, 3'd0, 15'h103, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd1, 0, 7, 3'd4, 15'h233, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd0, 0, 8, 3'd0, 15'h103, 0, 0, 1'b0, 3'd0, 1'b0, 1, 15'h600, 16'h1234, "R9");
    do_slot(2'd1, 0, 8, 3'd4, 15'h234, 0, 0, 1'b1, 3'd4, 1'b1, 0, 0, 0, "R5");
    do_slot(2'd0, 0, 9, 3'd0, 15'h103, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    do_slot(2'd1, 0, 9, 3'd4, 15'h235, 0, 0, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R5");
    idle();
    check(vmem[11'h600] == 16'h1234, "R5", "write in repeat slot", {16'd0, vmem[11'h600]}, 32'h1234);
  endtask

  task automatic t_sprites();
    spr_count_i = 6'd30;
    do_slot(2'd2, 0, 29, 3'd0, 15'h300, 0, 1, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R7");
    do_slot(2'd2, 0, 30, 3'd0, 15'h301, 0, 1, 1'b1, 3'd6, 1'b0, 0, 0, 0, "R7");
    do_slot(2'd2, 0, 33, 3'd0, 15'h302, 0, 1, 1'b1, 3'd6, 1'b0, 0, 0, 0, "R7");
    spr_count_i = 6'd34;
    do_slot(2'd2, 0, 33, 3'd0, 15'h303, 0, 1, 1'b0, 3'd0, 1'b0, 0, 0, 0, "R7");
    idle();
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) vmem[i] = 16'h0;
    vmem[11'h100] = 16'h0005;
    vmem[11'h101] = 16'h8012;
    vmem[11'h102] = 16'h8012;
    vmem[11'h103] = 16'h0012;
    repeat (3) @(posedge clk_i);
    #1 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_fill_collide();
    t_disabled_spare();
    t_transparent();
    t_priority();
    t_repeat();
    t_sprites();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule